// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block gathers the interrupt causes of a serial port and presents them to software as one 32-bit status word plus a single interrupt line. Five causes are tracked: receiver line errors, receive data available, receive character timeout, transmit space available and a change on the modem inputs. Each cause has its own pending latch, so several can be pending together. A cause is latched only if its enable bit is set. Software clears a cause by writing a one to its bit in the lowest byte of the status word.

The status word also shows the current modem input levels and a change flag for each modem input. The modem inputs are synchronised to the clock inside the block. The word also passes through the line-status byte and the receive fill count that the rest of the port provides. The FIFOs and the serializer sit outside this block and reach it only through event pulses and level inputs.

Top module: `uart_irq_unit`

## Requirements
- R1: Status word layout: bits 4:0 hold the pending causes (bit 0 line error, bit 1 data available, bit 2 character timeout, bit 3 transmit space, bit 4 modem change); bit 5 reads 0; bits 11:8 hold the modem change flags and bits 15:12 the synchronised modem levels, both ordered CTS, DSR, RI, DCD from the low bit; bits 23:16 equal `lsr_in`.
- R2: A cause becomes pending one clock after its event only if its enable is set: `ier[0]` gates data available and timeout, `ier[1]` transmit space, `ier[2]` line error, `ier[3]` modem change.
- R3: `irq` is high exactly when at least one of status bits 4:0 is set, and any combination of causes can be pending at the same time.
- R4: A write with `wr_en` high and `wr_lane` equal to 0 clears, at the next clock, each pending cause whose `wr_data` bit is 1 and leaves the others alone; a write with `wr_lane` not 0 changes nothing.
- R5: If a cause's event arrives in the same cycle as a clear of that cause, the cause stays pending.
- R6: A modem input change shows in the level bits two clocks after it is applied, and its change flag sets one clock later. This happens on rising and falling edges alike, whatever the value of `ier[3]`. All change flags clear when the modem cause is cleared.
- R7: The line-error event fires on a rising edge of the OR of `lsr_in` bits 1, 2, 3, 4 and 7. An error bit that stays high does not set the cause again after a clear, and bits 0, 5 and 6 never raise it.
- R8: Status bits 31:24 equal `rx_count[7:0]` and bits 7:6 equal `rx_count[9:8]`; clear writes do not change them.
- R9: After reset, no cause is pending, all change flags are 0 and `irq` is low.
- R10: Clearing an enable bit does not remove a cause that is already pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| modem_in | input | 4 | Asynchronous modem inputs: CTS, DSR, RI, DCD from bit 0 |
| lsr_in | input | 8 | Line-status bits from the receiver and transmitter |
| rx_count | input | 10 | Receive FIFO fill count |
| ev_rxdata | input | 1 | Pulse: receive data threshold reached |
| ev_timeout | input | 1 | Pulse: receive character timeout |
| ev_txspace | input | 1 | Pulse: transmit space available |
| ier | input | 4 | Cause enables |
| wr_en | input | 1 | Status word write strobe |
| wr_lane | input | 2 | Byte lane addressed by the write |
| wr_data | input | 5 | Cause bits to clear (low five bits of the written byte) |
| status | output | 32 | Status word |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps every event pattern against every enable pattern and then clears a partial mask. A wrong enable mapping, a clear that hits the wrong bits, or a cause that is lost when another is pending will all show up as a mismatch in the identification bits. Directed cases cover a set and a clear on the same cycle, where a design with clear priority drops an interrupt. They also cover writes to other byte lanes, which a careless design treats as clears. A held line error must not re-trigger after it is cleared, which a level-sensitive design would do. The modem checks sample the level and the change flag on each intermediate cycle, so a missing or extra synchroniser stage shows up as a timing error. Each modem line is toggled in both directions, which catches a design that detects only rising edges.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int ID_W      = 5;
    localparam int ID_LINE   = 0;
    localparam int ID_RXDATA = 1;
    localparam int ID_TMO    = 2;
    localparam int ID_TXSP   = 3;
    localparam int ID_MODEM  = 4;

    localparam int EN_W      = 4;
    localparam int EN_RX     = 0;
    localparam int EN_TX     = 1;
    localparam int EN_LINE   = 2;
    localparam int EN_MODEM  = 3;

    localparam int MODEM_W   = 4;
    localparam int LSR_W     = 8;
    localparam int CNT_W     = 10;
    localparam int LANE_W    = 2;

    // Error bits of the line-status byte: overrun, parity, framing, break, FIFO error
    localparam logic [LSR_W-1:0] LSR_ERR_MASK = 8'b1001_1110;

    typedef logic [ID_W-1:0] cause_t;

    function automatic cause_t gate_events(
        input logic            line_evt,
        input logic            rxd_evt,
        input logic            tmo_evt,
        input logic            txs_evt,
        input logic            mdm_evt,
        input logic [EN_W-1:0] en
    );
        cause_t v;
        v            = '0;
        v[ID_LINE]   = line_evt & en[EN_LINE];
        v[ID_RXDATA] = rxd_evt  & en[EN_RX];
        v[ID_TMO]    = tmo_evt  & en[EN_RX];
        v[ID_TXSP]   = txs_evt  & en[EN_TX];
        v[ID_MODEM]  = mdm_evt  & en[EN_MODEM];
        return v;
    endfunction

endpackage

// File: rtl/uart_irq_modem.sv
module uart_irq_modem #(
    parameter int N = 4,
    parameter int S = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    input  logic         clear_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] delta_o,
    output logic         change_o
);

    typedef struct packed {
        logic [S-1:0][N-1:0] sync;
        logic [N-1:0]        prev;
        logic [N-1:0]        delta;
    } mdm_state_t;

    mdm_state_t st_d, st_q;
    logic [N-1:0] edge_w;

    always_comb begin
        st_d         = st_q;
        st_d.sync[0] = async_i;
        for (int s = 1; s < S; s++) begin
            st_d.sync[s] = st_q.sync[s-1];
        end
        st_d.prev  = st_q.sync[S-1];
        edge_w     = st_q.sync[S-1] ^ st_q.prev;
        st_d.delta = (st_q.delta & ~{N{clear_i}}) | edge_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o  = st_q.sync[S-1];
    assign delta_o  = st_q.delta;
    assign change_o = |edge_w;

    for (genvar i = 0; i < N; i++) begin : g_chk
        AST_EDGE_SETS_DELTA: assert property (@(posedge clk) disable iff (!rst_n)
            edge_w[i] |=> delta_o[i]); // R6
        AST_DELTA_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (clear_i && !edge_w[i]) |=> !delta_o[i]); // R6
    end

endmodule

// File: rtl/uart_irq_pending.sv
module uart_irq_pending
    import uart_irq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  cause_t set_i,
    input  cause_t clr_i,
    output cause_t pend_o
);

    typedef struct packed {
        cause_t pend;
    } pend_state_t;

    pend_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < ID_W; i++) begin
            // an event in the clearing cycle wins
            st_d.pend[i] = set_i[i] | (st_q.pend[i] & ~clr_i[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    for (genvar i = 0; i < ID_W; i++) begin : g_chk
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> pend_o[i]); // R5
        AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !pend_o[i]); // R4
        AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i[i] && !set_i[i]) |=> $stable(pend_o[i])); // R10
    end

endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
    import uart_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MODEM_W-1:0] modem_in,
    input  logic [LSR_W-1:0]   lsr_in,
    input  logic [CNT_W-1:0]   rx_count,
    input  logic               ev_rxdata,
    input  logic               ev_timeout,
    input  logic               ev_txspace,
    input  logic [EN_W-1:0]    ier,
    input  logic               wr_en,
    input  logic [LANE_W-1:0]  wr_lane,
    input  logic [ID_W-1:0]    wr_data,
    output logic [31:0]        status,
    output logic               irq
);

    localparam int CNT_LO_W = 8;
    localparam int CNT_HI_W = CNT_W - CNT_LO_W;

    typedef struct packed {
        logic lsr_err_prev;
    } top_state_t;

    top_state_t st_d, st_q;

    logic               lsr_err_now;
    logic               line_evt;
    logic               clr_hit;
    cause_t             clr_mask;
    cause_t             set_vec;
    cause_t             pend;
    logic [MODEM_W-1:0] mdm_level;
    logic [MODEM_W-1:0] mdm_delta;
    logic               mdm_change;

    always_comb begin
        st_d              = st_q;
        lsr_err_now       = |(lsr_in & LSR_ERR_MASK);
        line_evt          = lsr_err_now & ~st_q.lsr_err_prev;
        st_d.lsr_err_prev = lsr_err_now;
        clr_hit           = wr_en && (wr_lane == '0);
        clr_mask          = clr_hit ? wr_data : '0;
        set_vec           = gate_events(line_evt, ev_rxdata, ev_timeout,
                                        ev_txspace, mdm_change, ier);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    uart_irq_modem #(
        .N (MODEM_W),
        .S (SYNC_STAGES)
    ) u_modem (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_i  (modem_in),
        .clear_i  (clr_mask[ID_MODEM]),
        .level_o  (mdm_level),
        .delta_o  (mdm_delta),
        .change_o (mdm_change)
    );

    uart_irq_pending u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .clr_i  (clr_mask),
        .pend_o (pend)
    );

    assign status = {rx_count[CNT_LO_W-1:0],
                     lsr_in,
                     mdm_level,
                     mdm_delta,
                     rx_count[CNT_W-1:CNT_W-CNT_HI_W],
                     1'b0,
                     pend};
    assign irq = |pend;

    AST_MODEM_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[ID_MODEM]) |-> $past(ier[EN_MODEM])); // R2
    AST_LINE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[ID_LINE]) |-> $past(ier[EN_LINE])); // R2
    AST_IRQ_FALLS_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(wr_en && wr_lane == '0)); // R3
    AST_OTHER_LANE_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_lane != '0 && irq) |=> irq); // R4

endmodule

// File: tb/uart_irq_unit_test.sv
module uart_irq_unit_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  modem_in;
    logic [7:0]  lsr_in;
    logic [9:0]  rx_count;
    logic        ev_rxdata, ev_timeout, ev_txspace;
    logic [3:0]  ier;
    logic        wr_en;
    logic [1:0]  wr_lane;
    logic [4:0]  wr_data;
    logic [31:0] status;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [4:0] exp_id;
    logic [3:0] exp_delta;
    logic [3:0] exp_level;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .modem_in(modem_in), .lsr_in(lsr_in),
        .rx_count(rx_count), .ev_rxdata(ev_rxdata), .ev_timeout(ev_timeout),
        .ev_txspace(ev_txspace), .ier(ier), .wr_en(wr_en), .wr_lane(wr_lane),
        .wr_data(wr_data), .status(status), .irq(irq)
    );

    function automatic logic [31:0] expect_word();
        return {rx_count[7:0], lsr_in, exp_level, exp_delta, rx_count[9:8], 1'b0, exp_id};
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, status, expect_word());
        chk({req, " irq"}, {31'd0, irq}, {31'd0, |exp_id});
    endtask

    task automatic clear(input logic [4:0] mask);
        wr_en = 1'b1; wr_lane = 2'd0; wr_data = mask;
        tick();
        wr_en = 1'b0;
        exp_id = exp_id & ~mask;
        if (mask[4]) exp_delta = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; modem_in = '0; lsr_in = '0; rx_count = 10'h2A5;
        ev_rxdata = 0; ev_timeout = 0; ev_txspace = 0; ier = '0;
        wr_en = 0; wr_lane = '0; wr_data = '0;
        exp_id = '0; exp_delta = '0; exp_level = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        chk_all("R9 reset state and R8 count fields");

        // Sweep: every enable pattern against every event pattern
        for (int e = 0; e < 16; e++) begin
            for (int m = 0; m < 32; m++) begin
                logic [4:0] c;
                int k;
                k = (e * 32 + m) % 4;
                ier = 4'(e);
                lsr_in = '0;
                clear(5'h1F);
                exp_id = '0;
                ev_rxdata  = m[1];
                ev_timeout = m[2];
                ev_txspace = m[3];
                lsr_in     = m[0] ? 8'h02 : 8'h00;
                if (m[4]) modem_in[k] = ~modem_in[k];
                tick();
                ev_rxdata = 0; ev_timeout = 0; ev_txspace = 0;
                exp_id[0] = m[0] & e[2];
                exp_id[1] = m[1] & e[0];
                exp_id[2] = m[2] & e[0];
                exp_id[3] = m[3] & e[1];
                // modem level visible after second edge, flag after third
                chk_all("R1 R2 R3 pulse causes after one edge");
                tick();
                exp_level = modem_in;
                chk_all("R6 level after two edges");
                tick();
                exp_id[4] = m[4] & e[3];
                if (m[4]) exp_delta = 4'(1 << k);
                chk_all("R1 R2 R3 R6 sweep");
                c = 5'(m) ^ {e[0], 4'(e)};
                clear(c);
                chk_all("R4 R7 partial clear");
            end
        end

        // R5: set and clear in the same cycle
        ier = 4'hF; lsr_in = '0;
        clear(5'h1F);
        ev_rxdata = 1'b1; wr_en = 1'b1; wr_lane = 2'd0; wr_data = 5'h02;
        tick();
        ev_rxdata = 1'b0; wr_en = 1'b0;
        exp_id = 5'h02;
        chk_all("R5 event beats clear");

        // R4: writes to other byte lanes change nothing
        for (int l = 1; l < 4; l++) begin
            wr_en = 1'b1; wr_lane = 2'(l); wr_data = 5'h1F;
            tick();
            wr_en = 1'b0;
            chk_all("R4 other lane ignored");
        end

        // R10: dropping the enable keeps the pending cause
        ier = 4'h0;
        tick();
        chk_all("R10 pending kept after enable drop");
        clear(5'h02);
        chk_all("R3 irq low after last clear");

        // R7: held error does not re-set; non-error bits never set
        ier = 4'hF;
        lsr_in = 8'h10;
        tick();
        exp_id = 5'h01;
        chk_all("R7 break edge sets line cause");
        clear(5'h01);
        tick(); tick();
        chk_all("R7 held error does not re-set");
        lsr_in = 8'h00; tick();
        lsr_in = 8'h61; tick(); tick();
        chk_all("R7 non-error bits ignored");
        lsr_in = 8'hE1; tick();
        exp_id = 5'h01;
        chk_all("R7 fifo error bit sets line cause");

        // R8: count fields follow input, not writes
        rx_count = 10'h15A;
        clear(5'h00);
        chk_all("R8 count fields");

        // R6: clear of modem cause wipes all flags; toggle with enable off
        ier = 4'h0;
        modem_in = ~modem_in;
        tick(); tick();
        exp_level = modem_in;
        chk_all("R6 levels after two edges");
        tick();
        exp_delta = 4'hF;
        chk_all("R6 flags without enable");
        clear(5'h10);
        chk_all("R6 flags cleared with modem cause");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule